// File: doc/BRIEF.md
# Oversampling Serial Receiver with Recovery

This block receives asynchronous serial frames on a single input line. The line is first resynchronised into the clock domain. Each bit period is then divided into 16 sample ticks, or 8 in the fast mode. A falling edge on an idle line opens a frame. The start bit is confirmed at its centre before any data is accepted. Every bit value comes from a two-of-three vote over the samples around the bit centre, so a single-sample disturbance on the line is filtered out.

The frame shape is chosen at run time: 5 to 9 data bits sent least significant bit first, an optional parity bit with odd or even sense, and one or two stop bits. Finished frames enter a two-entry first-in first-out buffer. The reader sees the oldest entry, its data and its own error flags on the read port, and removes it with a one-cycle pop. If a frame completes while both entries are still unread, that frame is discarded and a sticky overrun flag is raised.

Top module: `uart_rx_recover`

## Requirements
- R1: After reset, `rd_valid` and `rx_overrun` are 0.
- R2: `cfg_bits` selects the data length: 0 to 4 mean 5 to 9 bits, and 5 to 7 mean 9 bits. Bits arrive least significant first. `rd_data` holds them right-aligned, with the unused upper bits at zero.
- R3: When `cfg_par_en` is 1, one parity bit follows the data. `cfg_par_odd`=1 expects an odd count of ones across data and parity, and 0 expects an even count. `rd_perr` is 1 when the frame breaks this rule, and it is always 0 when parity is disabled.
- R4: `rd_ferr` is 1 when the first stop bit is voted low. The entry is still stored. A second stop bit is never examined.
- R5: A start bit that votes high at its centre is dropped as a false start. No entry is produced and the receiver waits for the next falling edge.
- R6: Each bit value is the majority of three samples: samples 8, 9 and 10 in 16x mode, and samples 4, 5 and 6 in 8x mode. A single disturbed sample does not change the bit.
- R7: The buffer returns entries in arrival order. `rd_valid` stays 1 while any entry is unread. A pop when the buffer is empty has no effect.
- R8: A frame that completes while two entries are unread and no pop is given is discarded, and `rx_overrun` goes to 1. The flag clears on the next accepted pop.
- R9: A frame that completes in the same cycle as a pop on a full buffer is stored, and `rx_overrun` stays 0.
- R10: `cfg_fast`=1 selects 8 samples per bit and `cfg_fast`=0 selects 16. Sampling advances only on cycles where `sample_tick` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sample_tick | input | 1 | Oversampling enable, one pulse per sample |
| rxd | input | 1 | Serial line, idle high |
| cfg_bits | input | 3 | Data length code (5 + code, capped at 9) |
| cfg_par_en | input | 1 | Parity bit present |
| cfg_par_odd | input | 1 | Odd parity when 1, even when 0 |
| cfg_fast | input | 1 | 8x oversampling when 1, 16x when 0 |
| rd_pop | input | 1 | Remove the oldest entry |
| rd_valid | output | 1 | Unread entry present (receive complete) |
| rd_data | output | 9 | Data of the oldest entry |
| rd_ferr | output | 1 | Frame error of the oldest entry |
| rd_perr | output | 1 | Parity error of the oldest entry |
| rx_overrun | output | 1 | A frame was lost because the buffer was full |

## Verification
The reader's pop and the buffer write of a completed frame can land in the same clock cycle, and on a full buffer that collision decides whether the frame is stored or lost. The bench fills both entries and then sends a third frame. It computes, from the frame length and the oversampling ratio, the exact cycle in which the buffer sees the completion, and pulses the pop in that cycle. It then requires the overrun flag to stay low and the two remaining entries to read back as the second and third frames. A separate run with no pop requires the third frame to disappear and the flag to rise.

// File: rtl/uart_rx_pkg.sv
package uart_rx_pkg;
  localparam int DATA_W = 9;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_START,
    ST_DATA,
    ST_PAR,
    ST_STOP
  } rx_state_e;

  typedef struct packed {
    logic [DATA_W-1:0] data;
    logic              ferr;
    logic              perr;
  } rx_entry_t;
endpackage

// File: rtl/rx_sync.sv
module rx_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic dout
);
  logic [STAGES-1:0] stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage_q <= {STAGES{RST_VAL}};
    else        stage_q <= {stage_q[STAGES-2:0], din};
  end

  assign dout = stage_q[STAGES-1];
endmodule

// File: rtl/rx_framer.sv
module rx_framer
  import uart_rx_pkg::*;
#(
  parameter int OSR_NORM = 16,
  parameter int OSR_FAST = 8
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      tick,
  input  logic      line,
  input  logic [2:0] cfg_bits,
  input  logic      cfg_par_en,
  input  logic      cfg_par_odd,
  input  logic      cfg_fast,
  output logic      push,
  output rx_entry_t entry
);
  localparam int CW = $clog2(OSR_NORM + 1);

  rx_state_e         st_q, st_d;
  logic [CW-1:0]     cnt_q, cnt_d;
  logic [3:0]        bit_q, bit_d;
  logic [DATA_W-1:0] sh_q, sh_d;
  logic [1:0]        vote_q, vote_d;
  logic              par_q, par_d;
  logic              push_q, push_d;
  rx_entry_t         ent_q, ent_d;

  logic [CW-1:0]     osr, vc0, vc1, vc2;
  logic [3:0]        nbits;
  logic              voted;
  logic [DATA_W-1:0] aligned;

  always_comb begin
    osr     = cfg_fast ? CW'(OSR_FAST) : CW'(OSR_NORM);
    vc0     = osr >> 1;
    vc1     = vc0 + CW'(1);
    vc2     = vc0 + CW'(2);
    nbits   = (cfg_bits > 3'd4) ? 4'd9 : ({1'b0, cfg_bits} + 4'd5);
    voted   = (vote_q[1] & vote_q[0]) | (vote_q[1] & line) | (vote_q[0] & line);
    aligned = sh_q >> (4'd9 - nbits);

    st_d   = st_q;
    cnt_d  = cnt_q;
    bit_d  = bit_q;
    sh_d   = sh_q;
    vote_d = vote_q;
    par_d  = par_q;
    push_d = 1'b0;
    ent_d  = ent_q;

    if (tick) begin
      if (st_q == ST_IDLE) begin
        if (!line) begin
          st_d  = ST_START;
          cnt_d = CW'(1);
          bit_d = 4'd0;
        end
      end else begin
        cnt_d = (cnt_q == osr) ? CW'(1) : cnt_q + CW'(1);
        if (cnt_q == vc0 || cnt_q == vc1) vote_d = {vote_q[0], line};
        if (cnt_q == vc2) begin
          case (st_q)
            ST_START: if (voted) st_d = ST_IDLE;
            ST_DATA:  sh_d = {voted, sh_q[DATA_W-1:1]};
            ST_PAR:   par_d = voted;
            ST_STOP: begin
              st_d       = ST_IDLE;
              push_d     = 1'b1;
              ent_d.data = aligned;
              ent_d.ferr = ~voted;
              ent_d.perr = cfg_par_en & (^aligned ^ par_q ^ cfg_par_odd);
            end
            default: ;
          endcase
        end
        if (cnt_q == osr) begin
          case (st_q)
            ST_START: st_d = ST_DATA;
            ST_DATA: begin
              bit_d = bit_q + 4'd1;
              if (bit_q == nbits - 4'd1) st_d = cfg_par_en ? ST_PAR : ST_STOP;
            end
            ST_PAR:  st_d = ST_STOP;
            default: ;
          endcase
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      cnt_q  <= '0;
      bit_q  <= '0;
      sh_q   <= '0;
      vote_q <= 2'b11;
      par_q  <= 1'b0;
      push_q <= 1'b0;
      ent_q  <= '0;
    end else begin
      st_q   <= st_d;
      cnt_q  <= cnt_d;
      bit_q  <= bit_d;
      sh_q   <= sh_d;
      vote_q <= vote_d;
      par_q  <= par_d;
      push_q <= push_d;
      ent_q  <= ent_d;
    end
  end

  assign push  = push_q;
  assign entry = ent_q;
endmodule

// File: rtl/rx_buf.sv
module rx_buf
  import uart_rx_pkg::*;
#(
  parameter int DEPTH = 2,
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push,
  input  rx_entry_t        wr_entry,
  input  logic             pop,
  output logic             valid,
  output rx_entry_t        rd_entry,
  output logic             overrun,
  output logic [CNT_W-1:0] count
);
  rx_entry_t        mem_q [DEPTH];
  logic [PW-1:0]    wp_q, wp_d, rp_q, rp_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             ovr_q, ovr_d;
  logic             do_pop, do_push, room;

  always_comb begin
    do_pop  = pop & (cnt_q != '0);
    room    = (cnt_q != CNT_W'(DEPTH)) | do_pop;
    do_push = push & room;
    wp_d    = wp_q;
    rp_d    = rp_q;
    if (do_push) wp_d = (wp_q == PW'(DEPTH - 1)) ? '0 : wp_q + PW'(1);
    if (do_pop)  rp_d = (rp_q == PW'(DEPTH - 1)) ? '0 : rp_q + PW'(1);
    cnt_d = cnt_q + CNT_W'(do_push) - CNT_W'(do_pop);
    ovr_d = ovr_q;
    if (push && !room) ovr_d = 1'b1;
    else if (do_pop)   ovr_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp_q  <= '0;
      rp_q  <= '0;
      cnt_q <= '0;
      ovr_q <= 1'b0;
    end else begin
      wp_q  <= wp_d;
      rp_q  <= rp_d;
      cnt_q <= cnt_d;
      ovr_q <= ovr_d;
    end
  end

  always_ff @(posedge clk) begin
    if (do_push) mem_q[wp_q] <= wr_entry;
  end

  assign valid    = (cnt_q != '0);
  assign rd_entry = mem_q[rp_q];
  assign overrun  = ovr_q;
  assign count    = cnt_q;
endmodule

// File: rtl/uart_rx_recover.sv
module uart_rx_recover
  import uart_rx_pkg::*;
#(
  parameter int OSR_NORM  = 16,
  parameter int OSR_FAST  = 8,
  parameter int BUF_DEPTH = 2,
  parameter int SYNC_LEN  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sample_tick,
  input  logic              rxd,
  input  logic [2:0]        cfg_bits,
  input  logic              cfg_par_en,
  input  logic              cfg_par_odd,
  input  logic              cfg_fast,
  input  logic              rd_pop,
  output logic              rd_valid,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_ferr,
  output logic              rd_perr,
  output logic              rx_overrun
);
  localparam int CNT_W = $clog2(BUF_DEPTH + 1);

  logic             rst_int_n;
  logic             line_s;
  logic             frm_push;
  rx_entry_t        frm_entry;
  rx_entry_t        head;
  logic             frm_perr;
  logic [CNT_W-1:0] buf_cnt;

  rx_sync #(.STAGES(2), .RST_VAL(1'b0)) u_rst_sync (
    .clk(clk), .rst_n(rst_n), .din(1'b1), .dout(rst_int_n)
  );

  rx_sync #(.STAGES(SYNC_LEN), .RST_VAL(1'b1)) u_line_sync (
    .clk(clk), .rst_n(rst_int_n), .din(rxd), .dout(line_s)
  );

  rx_framer #(.OSR_NORM(OSR_NORM), .OSR_FAST(OSR_FAST)) u_framer (
    .clk(clk), .rst_n(rst_int_n), .tick(sample_tick), .line(line_s),
    .cfg_bits(cfg_bits), .cfg_par_en(cfg_par_en), .cfg_par_odd(cfg_par_odd),
    .cfg_fast(cfg_fast), .push(frm_push), .entry(frm_entry)
  );

  rx_buf #(.DEPTH(BUF_DEPTH)) u_buf (
    .clk(clk), .rst_n(rst_int_n), .push(frm_push), .wr_entry(frm_entry),
    .pop(rd_pop), .valid(rd_valid), .rd_entry(head), .overrun(rx_overrun),
    .count(buf_cnt)
  );

  assign frm_perr = frm_entry.perr;
  assign rd_data  = head.data;
  assign rd_ferr  = head.ferr;
  assign rd_perr  = head.perr;
endmodule

// File: rtl/uart_rx_recover_chk.sv
module uart_rx_recover_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       rd_pop,
  input logic       rd_valid,
  input logic       rx_overrun,
  input logic       frm_push,
  input logic       frm_perr,
  input logic       cfg_par_en,
  input logic [1:0] buf_cnt
);
  p_cnt_bound_r7: assert property (@(posedge clk) disable iff (!rst_n)
    buf_cnt <= 2'd2);

  p_pop_empty_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!rd_valid && rd_pop && !frm_push) |=> !rd_valid);

  p_ovr_set_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rx_overrun) |-> $past(buf_cnt == 2'd2 && frm_push && !rd_pop));

  p_ovr_clr_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_overrun && rd_pop && rd_valid) |=> !rx_overrun);

  p_pop_push_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (buf_cnt == 2'd2 && frm_push && rd_pop) |=> (buf_cnt == 2'd2 && $stable(rx_overrun)));

  p_no_parity_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (frm_push && !cfg_par_en) |-> !frm_perr);
endmodule

bind uart_rx_recover uart_rx_recover_chk chk_i (
  .clk(clk), .rst_n(rst_n), .rd_pop(rd_pop), .rd_valid(rd_valid),
  .rx_overrun(rx_overrun), .frm_push(frm_push), .frm_perr(frm_perr),
  .cfg_par_en(cfg_par_en), .buf_cnt(buf_cnt)
);

// File: tb/uart_rx_recover_tb_top.sv
`timescale 1ns/1ps
module uart_rx_recover_tb_top;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       sample_tick;
  logic       rxd;
  logic [2:0] cfg_bits;
  logic       cfg_par_en, cfg_par_odd, cfg_fast;
  logic       rd_pop;
  logic       rd_valid, rd_ferr, rd_perr, rx_overrun;
  logic [8:0] rd_data;

  typedef struct {
    logic [8:0] d;
    logic       fe;
    logic       pe;
  } exp_t;

  exp_t exp_q[$];
  int   n_cmp = 0;
  int   n_bad = 0;
  int   model_cnt = 0;
  logic exp_ovr = 1'b0;
  bit   done = 1'b0;

  always #2.5 clk = ~clk;

  uart_rx_recover dut_i (
    .clk(clk), .rst_n(rst_n), .sample_tick(sample_tick), .rxd(rxd),
    .cfg_bits(cfg_bits), .cfg_par_en(cfg_par_en), .cfg_par_odd(cfg_par_odd),
    .cfg_fast(cfg_fast), .rd_pop(rd_pop), .rd_valid(rd_valid),
    .rd_data(rd_data), .rd_ferr(rd_ferr), .rd_perr(rd_perr),
    .rx_overrun(rx_overrun)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic int osr_now();
    return cfg_fast ? 8 : 16;
  endfunction

  // Driver: sends one frame and pushes the expected entry when it ends
  task automatic send_frame(input logic [8:0] d, input int n, input bit pen,
                            input bit podd, input bit bad_par, input bit bad_stop,
                            input bit glitch);
    logic [12:0] seq;
    int          len;
    logic        p;
    logic [8:0]  dm;
    exp_t        e;
    int          osr;
    cfg_bits    = 3'(n - 5);
    cfg_par_en  = pen;
    cfg_par_odd = podd;
    osr = osr_now();
    dm  = d & 9'((1 << n) - 1);
    p   = podd ? ~(^dm) : ^dm;
    if (bad_par) p = ~p;
    seq = '0;
    len = 0;
    seq[len++] = 1'b0;
    for (int i = 0; i < n; i++) seq[len++] = dm[i];
    if (pen) seq[len++] = p;
    seq[len++] = bad_stop ? 1'b0 : 1'b1;
    for (int k = 0; k < len; k++) begin
      for (int c = 0; c < osr; c++) begin
        @(negedge clk);
        rxd = (glitch && k == 2 && c == osr / 2 + 1) ? ~seq[k] : seq[k];
      end
    end
    @(negedge clk);
    rxd = 1'b1;
    if (model_cnt == 2) exp_ovr = 1'b1;
    else begin
      e.d  = dm;
      e.fe = bad_stop;
      e.pe = pen & bad_par;
      exp_q.push_back(e);
      model_cnt++;
    end
    repeat (3 * osr) @(negedge clk);
  endtask

  // Monitor: compares the head entry with the scoreboard and pops it
  task automatic mon_pop(input string tag);
    exp_t e;
    @(negedge clk);
    check(rd_valid === 1'b1, {tag, " R7 valid"}, rd_valid, 1);
    check(rx_overrun === exp_ovr, {tag, " R8 overrun"}, rx_overrun, exp_ovr);
    if (exp_q.size() == 0) begin
      check(1'b0, {tag, " R7 empty scoreboard"}, 0, 1);
    end else begin
      e = exp_q.pop_front();
      check(rd_data === e.d, {tag, " R2 data"}, rd_data, e.d);
      check(rd_ferr === e.fe, {tag, " R4 ferr"}, rd_ferr, e.fe);
      check(rd_perr === e.pe, {tag, " R3 perr"}, rd_perr, e.pe);
    end
    rd_pop = 1'b1;
    @(negedge clk);
    rd_pop = 1'b0;
    model_cnt--;
    exp_ovr = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; sample_tick = 1'b1; rxd = 1'b1; rd_pop = 1'b0;
    cfg_bits = 3'd3; cfg_par_en = 1'b0; cfg_par_odd = 1'b0; cfg_fast = 1'b0;
    repeat (4) @(negedge clk);
    check(rd_valid === 1'b0, "R1 valid after reset", rd_valid, 0);
    check(rx_overrun === 1'b0, "R1 overrun after reset", rx_overrun, 0);
    rst_n = 1'b1;
    repeat (8) @(negedge clk);

    // R2 formats, R3 parity senses
    send_frame(9'h0A5, 8, 0, 0, 0, 0, 0); mon_pop("R2 8n1");
    send_frame(9'h013, 5, 1, 0, 0, 0, 0); mon_pop("R3 5e1");
    send_frame(9'h05A, 7, 1, 1, 0, 0, 0); mon_pop("R3 7o1");
    send_frame(9'h1C3, 9, 1, 0, 0, 0, 0); mon_pop("R2 9e1");
    send_frame(9'h036, 6, 1, 1, 1, 0, 0); mon_pop("R3 bad odd parity");
    send_frame(9'h0C9, 8, 1, 0, 1, 0, 0); mon_pop("R3 bad even parity");

    // R4 bad stop; trailing low then rejected as a false start (R5)
    send_frame(9'h07E, 8, 0, 0, 0, 1, 0); mon_pop("R4 bad stop");
    repeat (40) @(negedge clk);
    check(rd_valid === 1'b0, "R5 no entry after stop tail", rd_valid, 0);

    // R5 short low pulse on an idle line
    @(negedge clk); rxd = 1'b0;
    repeat (3) @(negedge clk); rxd = 1'b1;
    repeat (60) @(negedge clk);
    check(rd_valid === 1'b0, "R5 false start dropped", rd_valid, 0);

    // R6 single-sample glitch at a bit centre
    send_frame(9'h0F0, 8, 0, 0, 0, 0, 1); mon_pop("R6 glitch 16x");

    // R10 fast mode
    cfg_fast = 1'b1;
    repeat (8) @(negedge clk);
    send_frame(9'h02D, 6, 1, 1, 0, 0, 0); mon_pop("R10 8x 6o1");
    send_frame(9'h155, 9, 0, 0, 0, 0, 1); mon_pop("R10 R6 8x glitch");
    cfg_fast = 1'b0;
    repeat (8) @(negedge clk);

    // R8 overrun: three frames unread
    send_frame(9'h011, 8, 0, 0, 0, 0, 0);
    send_frame(9'h022, 8, 0, 0, 0, 0, 0);
    send_frame(9'h033, 8, 0, 0, 0, 0, 0);
    mon_pop("R8 first");
    mon_pop("R8 second");
    check(rd_valid === 1'b0, "R8 third frame discarded", rd_valid, 0);
    check(rx_overrun === 1'b0, "R8 flag cleared by pop", rx_overrun, 0);

    // R7 pop on empty has no effect
    @(negedge clk); rd_pop = 1'b1;
    @(negedge clk); rd_pop = 1'b0;
    @(negedge clk);
    check(rd_valid === 1'b0, "R7 empty pop valid", rd_valid, 0);
    send_frame(9'h044, 8, 0, 0, 0, 0, 0); mon_pop("R7 after empty pop");

    // R9 pop in the very cycle the third frame is written
    send_frame(9'h101, 9, 0, 0, 0, 0, 0);
    send_frame(9'h102, 9, 0, 0, 0, 0, 0);
    fork
      send_frame(9'h103, 9, 0, 0, 0, 0, 0);
      begin
        @(negedge clk);
        repeat ((1 + 9) * 16 + 8 + 6 - 1) @(posedge clk);
        mon_pop("R9 same-cycle pop");
      end
    join
    check(rx_overrun === 1'b0, "R9 no overrun", rx_overrun, 0);
    mon_pop("R9 second");
    mon_pop("R9 third kept");
    check(rd_valid === 1'b0, "R7 drained", rd_valid, 0);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule